// File: doc/BRIEF.md
# Interlaced Scan Position Timing Generator

This block produces the live scan position for a display controller: a signed horizontal coordinate, a signed vertical coordinate and a field flag. It counts one step per scan clock along a line. At the end of a line it advances to the next line. At the end of a field it moves to the other field when interlacing is in use. Start and stop points are programmed relative to the top-left corner of the visible area. A counter therefore begins at negative coordinates before the visible origin and counts up through zero. Downstream sync pulse generators compare these coordinates against their own switch-on and switch-off points.

A small register interface with separate write and read addresses holds the settings. The odd field has a start point and a stop point, each with both coordinates. The even field has vertical start and stop values only and takes its horizontal limits from the odd field. The interface also holds an enable switch and a line width in scan dots, which is stored for readback. A read-only diagnostic address returns the live position packed in the same layout the sync generators use.

Top module: `scan_timing_gen`

## Requirements
- R1: After reset every writable register reads zero, the switch is off, and the position outputs are x=0, y=0, field=0.
- R2: While the switch (address 4, bit 0; 1 = on) is off, the position is loaded every clock with the odd-field start x and start y, and field is 0.
- R3: While the switch is on and x differs from the odd stop x, x increases by one each clock, while y and field are unchanged.
- R4: When x equals the odd stop x, the next x is the odd start x and y increases by one, unless y is at the current field's stop y.
- R5: In interlaced mode (even start y or even stop y nonzero), when x and y both reach the odd field's stop point, field becomes 1 (even) and y loads the even start y.
- R6: In the even field the horizontal limits are the odd field's. When x reaches the odd stop x and y reaches the even stop y, field becomes 0 and y loads the odd start y.
- R7: In non-interlaced mode (even start y and even stop y both zero), field stays 0 and the end of the field reloads y with the odd start y.
- R8: Coordinates are 15-bit two's complement, so a negative start such as x=-2 counts -2, -1, 0, 1.
- R9: Read address 6 returns the live position with x in bits [30:16], field in bit 15 and y in bits [14:0].
- R10: Register map for writes and reads: 0 = odd start and 1 = odd stop (x in [30:16], y in [14:0]); 2 = even start y and 3 = even stop y (in [14:0]); 4 = switch (bit 0); 5 = line width (in [29:16]). Written bits outside these fields are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pos_x | output | 15 | Current x, two's complement |
| pos_y | output | 15 | Current y, two's complement |
| field | output | 1 | Current field (0 odd, 1 even) |

## Verification
The bench starts the counter at negative coordinates. A design that treated coordinates as unsigned, or compared them with a signed-magnitude compare, would then skip the zero crossing or never reach the stop point. It runs non-interlaced first and then interlaced across both field changes. This catches a design that toggles field with the even limits at zero, or that reloads y with the wrong field's start. The even field must use the odd stop x for its line ends, so a design that kept separate horizontal limits would wrap at the wrong column. Writes with every bit set show whether bits outside the fields are kept. Turning the switch off mid-run shows whether the counter returns to the odd start or simply freezes.

// File: rtl/scan_timing_gen.sv
module scan_timing_gen #(
  parameter int CW = 15,
  parameter int LW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [2:0]           rd_addr,
  output logic [31:0]          rd_data,
  output logic signed [CW-1:0] pos_x,
  output logic signed [CW-1:0] pos_y,
  output logic                 field
);
  localparam int XLSB = 16;

  logic [CW-1:0] odd_sx, odd_sy, odd_px, odd_py, even_sy, even_py;
  logic [CW-1:0] cx, cy;
  logic [LW-1:0] line_w;
  logic          sw, fld;

  function automatic logic [31:0] pad(input logic [CW-1:0] v);
    return {{(32-CW){1'b0}}, v};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_sx <= '0; odd_sy <= '0; odd_px <= '0; odd_py <= '0;
      even_sy <= '0; even_py <= '0; line_w <= '0; sw <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin odd_sx <= wr_data[XLSB +: CW]; odd_sy <= wr_data[CW-1:0]; end
        3'd1: begin odd_px <= wr_data[XLSB +: CW]; odd_py <= wr_data[CW-1:0]; end
        3'd2: even_sy <= wr_data[CW-1:0];
        3'd3: even_py <= wr_data[CW-1:0];
        3'd4: sw <= wr_data[0];
        3'd5: line_w <= wr_data[XLSB +: LW];
        default: ;
      endcase
    end
  end

  wire           interlaced = (|even_sy) | (|even_py);
  wire [CW-1:0]  stop_y     = fld ? even_py : odd_py;
  wire           x_end      = (cx == odd_px);
  wire           y_end      = (cy == stop_y);
  wire           nxt_fld    = interlaced & ~fld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cx <= '0; cy <= '0; fld <= 1'b0;
    end else if (!sw) begin
      cx <= odd_sx; cy <= odd_sy; fld <= 1'b0;
    end else if (x_end) begin
      cx <= odd_sx;
      if (y_end) begin
        fld <= nxt_fld;
        cy  <= nxt_fld ? even_sy : odd_sy;
      end else begin
        cy <= cy + CW'(1);
      end
    end else begin
      cx <= cx + CW'(1);
    end
  end

  assign pos_x = cx;
  assign pos_y = cy;
  assign field = fld;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = (pad(odd_sx) << XLSB) | pad(odd_sy);
      3'd1:    rd_data = (pad(odd_px) << XLSB) | pad(odd_py);
      3'd2:    rd_data = pad(even_sy);
      3'd3:    rd_data = pad(even_py);
      3'd4:    rd_data = {31'b0, sw};
      3'd5:    rd_data = {{(32-LW){1'b0}}, line_w} << XLSB;
      3'd6:    rd_data = (pad(cx) << XLSB) | {16'b0, fld, cy};
      default: rd_data = '0;
    endcase
  end
endmodule

module scan_timing_gen_chk #(parameter int CW = 15) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw,
  input logic [CW-1:0] odd_sx,
  input logic [CW-1:0] odd_sy,
  input logic [CW-1:0] odd_px,
  input logic [CW-1:0] odd_py,
  input logic [CW-1:0] even_sy,
  input logic [CW-1:0] even_py,
  input logic [CW-1:0] pos_x,
  input logic [CW-1:0] pos_y,
  input logic          field
);
  wire il = (|even_sy) | (|even_py);
  wire lend = (pos_x == odd_px);
  wire fend = lend && (pos_y == (field ? even_py : odd_py));

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw |=> (pos_x == $past(odd_sx)) && (pos_y == $past(odd_sy)) && !field); // R2
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sw && !lend |=> (pos_x == $past(pos_x) + CW'(1)) && $stable(pos_y) && $stable(field)); // R3
  AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sw && lend |=> pos_x == $past(odd_sx)); // R4
  AST_Y_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sw && lend && !fend |=> pos_y == $past(pos_y) + CW'(1)); // R4
  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    sw && fend && il && !field |=> field && (pos_y == $past(even_sy))); // R5
  AST_FIELD_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    sw && fend && field |=> !field && (pos_y == $past(odd_sy))); // R6
  AST_PROG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !il && !field |=> !field); // R7
endmodule

bind scan_timing_gen scan_timing_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw(sw),
  .odd_sx(odd_sx), .odd_sy(odd_sy), .odd_px(odd_px), .odd_py(odd_py),
  .even_sy(even_sy), .even_py(even_py),
  .pos_x(cx), .pos_y(cy), .field(fld)
);

// File: tb/scan_timing_gen_test.sv
`timescale 1ns/1ps
module scan_timing_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [2:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic signed [14:0] pos_x, pos_y;
  logic        field;

  int errors = 0;
  int checks = 0;
  bit track = 0;
  bit done = 0;
  string tag = "R2";

  scan_timing_gen uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pos_x(pos_x), .pos_y(pos_y), .field(field));

  always #4 clk = ~clk;

  logic [14:0] m_osx, m_osy, m_opx, m_opy, m_esy, m_epy;
  logic        m_sw;
  logic [14:0] m_x, m_y;
  logic        m_f;
  logic [30:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_osx = 0; m_osy = 0; m_opx = 0; m_opy = 0; m_esy = 0; m_epy = 0;
      m_sw = 0; m_x = 0; m_y = 0; m_f = 0;
    end else begin
      if (!m_sw) begin
        m_x = m_osx; m_y = m_osy; m_f = 0;
      end else if (m_x == m_opx) begin
        m_x = m_osx;
        if (m_y == (m_f ? m_epy : m_opy)) begin
          m_f = (m_esy != 0 || m_epy != 0) ? ~m_f : 1'b0;
          m_y = m_f ? m_esy : m_osy;
        end else m_y = m_y + 1;
      end else m_x = m_x + 1;
      if (wr_en) case (wr_addr)
        0: begin m_osx = wr_data[30:16]; m_osy = wr_data[14:0]; end
        1: begin m_opx = wr_data[30:16]; m_opy = wr_data[14:0]; end
        2: m_esy = wr_data[14:0];
        3: m_epy = wr_data[14:0];
        4: m_sw = wr_data[0];
        default: ;
      endcase
    end
    if (track) begin
      exp_q.push_back({m_x, m_f, m_y});
      tag_q.push_back(tag);
    end
  end

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [30:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({pos_x, field, pos_y} !== e) begin
        errors++;
        $display("FAIL %s position: got x=%0d y=%0d f=%0b expected x=%0d y=%0d f=%0b",
          t, pos_x, pos_y, field, $signed(e[30:16]), $signed(e[14:0]), e[15]);
      end
      if (rd_addr == 6) begin
        checks++;
        if (rd_data !== {1'b0, e}) begin
          errors++;
          $display("FAIL R9 diagnostic word: got %h expected %h", rd_data, {1'b0, e});
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string t);
    @(negedge clk); rd_addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d: got %h expected %h", t, a, rd_data, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired: got hang expected finish");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 7; a++) rd_check(a[2:0], 32'h0, "R1");
    checks++;
    if (pos_x !== 0 || pos_y !== 0 || field !== 0) begin
      errors++;
      $display("FAIL R1 reset position: got %0d %0d %0b expected 0 0 0", pos_x, pos_y, field);
    end
    rd_addr = 6;
    track = 1;
    tag = "R2";
    wr(0, {1'b0, 15'h7FFE, 1'b0, 15'h7FFF});
    wr(1, {1'b0, 15'd1, 1'b0, 15'd1});
    idle(3);
    tag = "R3 R4 R7 R8";
    wr(4, 32'h1);
    idle(30);
    tag = "R5 R6";
    wr(2, 32'd5);
    wr(3, 32'd6);
    idle(40);
    tag = "R2";
    wr(4, 32'h0);
    idle(3);
    track = 0;
    idle(2);
    wr(4, 32'hFFFF_FFFE);
    rd_check(4, 32'h0, "R10");
    wr(4, 32'hFFFF_FFFF);
    rd_check(4, 32'h1, "R10");
    wr(4, 32'h0);
    wr(5, 32'hFFFF_FFFF);
    rd_check(5, 32'h3FFF_0000, "R10");
    wr(2, 32'hFFFF_FFFF);
    rd_check(2, 32'h0000_7FFF, "R10");
    wr(0, 32'hFFFF_FFFF);
    rd_check(0, 32'h7FFF_7FFF, "R10");
    rd_check(1, 32'h0001_0001, "R10");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule